// File: doc/BRIEF.md
# Quadrature Position Decoder

This block turns two encoder phase inputs into up and down steps of a position counter. Phase A arrives on the input pin of timer channel 0 and phase B on the input pin of timer channel 1. Each phase first passes a two-stage synchronizer. It then passes an optional polarity inversion and a glitch filter with its own programmable length. The cleaned phases feed one of two decoders. The quadrature decoder counts every edge of both phases. The count/direction decoder counts rising edges of phase A, and the level of phase B gives the direction.

The position counter runs from 0 up to a programmable limit and wraps at either end. Each wrap produces a one-cycle strobe. A direction output shows the sense of the last step taken. A single enable turns the decoder on. While it is on, the block reports that it owns timer channels 0 and 1, so the surrounding timer must not use them for waveform generation or capture. Clearing the enable freezes the counter and hands both channels back.

Top module: `quad_pos_decoder`

## Requirements
- R1: After reset, `position` is 0, `dirUp` is 0, `ovfStrobe` and `unfStrobe` are 0, and `lowChanClaim` follows `decEn`.
- R2: With `decMode`=0 (quadrature), a phase sequence in which A leads B moves the counter up by one on every edge of either phase. The sequence of (A,B) states is 00, 10, 11, 01, 00, so one full cycle adds 4.
- R3: With `decMode`=0, the reverse sequence (B leads A) moves the counter down by one on every edge.
- R4: With `decMode`=1 (count/direction), each rising edge of filtered A gives one step: up when filtered B is 1 and down when it is 0. Falling edges of A and any change of B give no step.
- R5: When `polA` is 1, phase A is inverted before filtering and decoding (likewise `polB` for B). A forward raw sequence then counts down.
- R6: When a phase's filter length F is nonzero, a change on that phase reaches the decoder only after it has held for 4*F consecutive clocks. Shorter pulses are dropped. F=0 bypasses the filter.
- R7: An up step taken at `position` >= `modVal` loads 0, pulses `ovfStrobe` for one cycle, and sets `dirUp` to 1.
- R8: A down step taken at `position`=0 loads `modVal`, pulses `unfStrobe` for one cycle, and clears `dirUp`.
- R9: While `decEn` is 0, `position` holds, no strobe fires, and `lowChanClaim` is 0. While `decEn` is 1, `lowChanClaim` is 1.
- R10: In quadrature mode, a change of both filtered phases in the same cycle is treated as invalid and gives no step.
- R11: `dirUp` is 1 after an up step and 0 after a down step, and holds between steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| decEn | input | 1 | Decoder enable; claims channels 0 and 1 |
| decMode | input | 1 | 0 = quadrature x4, 1 = count/direction |
| polA | input | 1 | Invert phase A |
| polB | input | 1 | Invert phase B |
| fltLenA | input | 4 | Filter length for phase A (units of 4 clocks) |
| fltLenB | input | 4 | Filter length for phase B (units of 4 clocks) |
| modVal | input | 16 | Counter upper limit |
| phaseA | input | 1 | Phase A from channel 0 input pin |
| phaseB | input | 1 | Phase B from channel 1 input pin |
| position | output | 16 | Position counter |
| dirUp | output | 1 | Direction of last step (1 = up) |
| ovfStrobe | output | 1 | One-cycle pulse on upward wrap |
| unfStrobe | output | 1 | One-cycle pulse on downward wrap |
| lowChanClaim | output | 1 | Channels 0 and 1 are held by the decoder |

## Verification
The wrap properties compare `position` against `modVal` in the same cycle. They therefore assume that `modVal` does not change in the cycle a wrap occurs, and that the counter never sits above the limit when a wrap fires. The stimulus changes `modVal` only while the phases are idle, and only to a value at or above the current count. Polarity and mode changes would create a false edge on the cleaned phases, so the bench makes them only while the decoder is disabled. It also holds each phase level long enough for the configured filter before it takes the next step.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

  typedef enum logic {
    DEC_QUAD   = 1'b0,
    DEC_CNTDIR = 1'b1
  } decMode_e;

  // one-cycle step request from the control to the datapath
  typedef struct packed {
    logic inc;
    logic dec;
  } stepCmd_t;

endpackage

// File: rtl/qdec_glitch_filter.sv
module qdec_glitch_filter #(
  parameter int FLT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pinIn,
  input  logic             invert,
  input  logic [FLT_W-1:0] fltLen,
  output logic             clean
);

  localparam int LIM_W = FLT_W + 2;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   rawLvl;
  logic [LIM_W-1:0]       stableCnt;
  logic [LIM_W-1:0]       limit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], pinIn};
  end

  assign rawLvl = syncQ[SYNC_STAGES-1] ^ invert;
  assign limit  = {fltLen, 2'b00};

  // the level moves to the output only after 4*fltLen equal samples
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clean     <= 1'b0;
      stableCnt <= '0;
    end else if (fltLen == '0) begin
      clean     <= rawLvl;
      stableCnt <= '0;
    end else if (rawLvl == clean) begin
      stableCnt <= '0;
    end else if (stableCnt >= limit - LIM_W'(1)) begin
      clean     <= rawLvl;
      stableCnt <= '0;
    end else begin
      stableCnt <= stableCnt + LIM_W'(1);
    end
  end

endmodule

// File: rtl/qdec_ctrl.sv
module qdec_ctrl
  import qdec_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     decEn,
  input  decMode_e mode,
  input  logic     fA,
  input  logic     fB,
  output stepCmd_t cmd
);

  logic prevA, prevB;
  logic edgeA, edgeB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevA <= 1'b0;
      prevB <= 1'b0;
    end else begin
      prevA <= fA;
      prevB <= fB;
    end
  end

  assign edgeA = fA ^ prevA;
  assign edgeB = fB ^ prevB;

  always_comb begin
    cmd = '0;
    if (decEn) begin
      unique case (mode)
        DEC_QUAD: begin
          // exactly one phase moved; A-leads-B gives fA != prevB
          if (edgeA ^ edgeB) begin
            if (fA ^ prevB) cmd.inc = 1'b1;
            else            cmd.dec = 1'b1;
          end
        end
        DEC_CNTDIR: begin
          if (fA && !prevA) begin
            if (fB) cmd.inc = 1'b1;
            else    cmd.dec = 1'b1;
          end
        end
        default: cmd = '0;
      endcase
    end
  end

endmodule

// File: rtl/qdec_datapath.sv
module qdec_datapath
  import qdec_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  stepCmd_t         cmd,
  input  logic [CNT_W-1:0] modVal,
  output logic [CNT_W-1:0] count,
  output logic             dirUp,
  output logic             ovf,
  output logic             unf
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
      dirUp <= 1'b0;
      ovf   <= 1'b0;
      unf   <= 1'b0;
    end else begin
      ovf <= 1'b0;
      unf <= 1'b0;
      if (cmd.inc) begin
        dirUp <= 1'b1;
        if (count >= modVal) begin
          count <= '0;
          ovf   <= 1'b1;
        end else begin
          count <= count + CNT_W'(1);
        end
      end else if (cmd.dec) begin
        dirUp <= 1'b0;
        if (count == '0) begin
          count <= modVal;
          unf   <= 1'b1;
        end else begin
          count <= count - CNT_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/quad_pos_decoder.sv
module quad_pos_decoder
  import qdec_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int FLT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             decEn,
  input  logic             decMode,
  input  logic             polA,
  input  logic             polB,
  input  logic [FLT_W-1:0] fltLenA,
  input  logic [FLT_W-1:0] fltLenB,
  input  logic [CNT_W-1:0] modVal,
  input  logic             phaseA,
  input  logic             phaseB,
  output logic [CNT_W-1:0] position,
  output logic             dirUp,
  output logic             ovfStrobe,
  output logic             unfStrobe,
  output logic             lowChanClaim
);

  localparam int NUM_PH = 2;

  logic [NUM_PH-1:0]            pinVec, polVec, cleanVec;
  logic [NUM_PH-1:0][FLT_W-1:0] lenVec;
  stepCmd_t                     stepCmd;

  assign pinVec = {phaseB, phaseA};
  assign polVec = {polB, polA};
  assign lenVec = {fltLenB, fltLenA};

  for (genvar g = 0; g < NUM_PH; g++) begin : g_phase
    qdec_glitch_filter #(
      .FLT_W      (FLT_W),
      .SYNC_STAGES(SYNC_STAGES)
    ) u_flt (
      .clk   (clk),
      .rstN  (rstN),
      .pinIn (pinVec[g]),
      .invert(polVec[g]),
      .fltLen(lenVec[g]),
      .clean (cleanVec[g])
    );
  end

  qdec_ctrl u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .decEn(decEn),
    .mode (decMode_e'(decMode)),
    .fA   (cleanVec[0]),
    .fB   (cleanVec[1]),
    .cmd  (stepCmd)
  );

  qdec_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .cmd   (stepCmd),
    .modVal(modVal),
    .count (position),
    .dirUp (dirUp),
    .ovf   (ovfStrobe),
    .unf   (unfStrobe)
  );

  assign lowChanClaim = decEn;

endmodule

// File: rtl/qdec_checker.sv
module qdec_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             decEn,
  input logic [CNT_W-1:0] modVal,
  input logic [CNT_W-1:0] position,
  input logic             dirUp,
  input logic             ovfStrobe,
  input logic             unfStrobe,
  input logic             cmdInc,
  input logic             cmdDec
);

  p_single_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (position != $past(position)) |->
      (position == $past(position) + 1'b1) || (position == $past(position) - 1'b1)
      || ovfStrobe || unfStrobe);

  p_ovf_wrap_r7: assert property (@(posedge clk) disable iff (!rstN)
    ovfStrobe |-> (position == '0) && dirUp);

  p_unf_wrap_r8: assert property (@(posedge clk) disable iff (!rstN)
    unfStrobe |-> (position == modVal) && !dirUp);

  p_flag_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(ovfStrobe && unfStrobe));

  p_hold_off_r9: assert property (@(posedge clk) disable iff (!rstN)
    !decEn |=> $stable(position) && !ovfStrobe && !unfStrobe);

  p_dir_up_r11: assert property (@(posedge clk) disable iff (!rstN)
    cmdInc |=> dirUp);

  p_dir_dn_r11: assert property (@(posedge clk) disable iff (!rstN)
    cmdDec |=> !dirUp);

endmodule

bind quad_pos_decoder qdec_checker #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .decEn    (decEn),
  .modVal   (modVal),
  .position (position),
  .dirUp    (dirUp),
  .ovfStrobe(ovfStrobe),
  .unfStrobe(unfStrobe),
  .cmdInc   (stepCmd.inc),
  .cmdDec   (stepCmd.dec)
);

// File: tb/tb_quad_pos_decoder.sv
module tb_quad_pos_decoder;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        decEn = 1'b0, decMode = 1'b0, polA = 1'b0, polB = 1'b0;
  logic [3:0]  fltLenA = '0, fltLenB = '0;
  logic [15:0] modVal = 16'd1000;
  logic        phaseA = 1'b0, phaseB = 1'b0;
  logic [15:0] position;
  logic        dirUp, ovfStrobe, unfStrobe, lowChanClaim;

  int checks = 0, failures = 0;
  int ovfSeen = 0, unfSeen = 0;
  int settle = 8;
  bit done = 1'b0;

  quad_pos_decoder dut (
    .clk(clk), .rstN(rstN), .decEn(decEn), .decMode(decMode),
    .polA(polA), .polB(polB), .fltLenA(fltLenA), .fltLenB(fltLenB),
    .modVal(modVal), .phaseA(phaseA), .phaseB(phaseB),
    .position(position), .dirUp(dirUp), .ovfStrobe(ovfStrobe),
    .unfStrobe(unfStrobe), .lowChanClaim(lowChanClaim)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (rstN) begin
      if (ovfStrobe) ovfSeen++;
      if (unfStrobe) unfSeen++;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setAB(input logic a, input logic b);
    @(posedge clk); #1;
    phaseA = a; phaseB = b;
    repeat (settle) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic setEn(input logic en);
    @(posedge clk); #1;
    decEn = en;
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulseA(input logic b);
    setAB(1'b1, b);
    setAB(1'b0, b);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 position", position, 0);
    check("R1 dirUp", dirUp, 0);
    check("R1 strobes", ovfStrobe | unfStrobe, 0);
    check("R1 claim idle", lowChanClaim, 0);
  endtask

  task automatic t_forward;
    setEn(1'b1);
    check("R9 claim when enabled", lowChanClaim, 1);
    for (int i = 0; i < 2; i++) begin
      setAB(1, 0); setAB(1, 1); setAB(0, 1); setAB(0, 0);
    end
    check("R2 forward x4 count", position, 8);
    check("R11 dir after up", dirUp, 1);
  endtask

  task automatic t_reverse;
    setAB(0, 1); setAB(1, 1); setAB(1, 0);
    check("R3 reverse count", position, 5);
    check("R11 dir after down", dirUp, 0);
  endtask

  task automatic t_both;
    setAB(0, 1);
    check("R10 simultaneous change ignored", position, 5);
    setAB(0, 0);
    check("R10 next valid step counts", position, 6);
  endtask

  task automatic t_polarity;
    setEn(1'b0);
    @(posedge clk); #1; polA = 1'b1;
    repeat (8) @(posedge clk); @(negedge clk);
    check("R9 hold while disabled", position, 6);
    setEn(1'b1);
    setAB(1, 0); setAB(1, 1); setAB(0, 1); setAB(0, 0);
    check("R5 inverted A counts down", position, 2);
    setEn(1'b0);
    @(posedge clk); #1; polA = 1'b0;
    repeat (8) @(posedge clk);
    setEn(1'b1);
  endtask

  task automatic t_cntdir;
    setEn(1'b0);
    @(posedge clk); #1; decMode = 1'b1;
    setEn(1'b1);
    setAB(0, 1);
    check("R4 B change gives no step", position, 2);
    for (int i = 0; i < 3; i++) pulseA(1'b1);
    check("R4 rising A with B high counts up", position, 5);
    setAB(0, 0);
    pulseA(1'b0); pulseA(1'b0);
    check("R4 rising A with B low counts down", position, 3);
    check("R11 dir after cntdir down", dirUp, 0);
  endtask

  task automatic t_filter;
    setEn(1'b0);
    @(posedge clk); #1; decMode = 1'b0; fltLenA = 4'd3;
    settle = 22;
    setEn(1'b1);
    @(posedge clk); #1; phaseA = 1'b1;
    repeat (6) @(posedge clk); #1; phaseA = 1'b0;
    repeat (22) @(posedge clk); @(negedge clk);
    check("R6 short pulse dropped", position, 3);
    setAB(1, 0);
    check("R6 long level passes", position, 4);
    setAB(0, 0);
    check("R6 long level returns", position, 3);
    @(posedge clk); #1; fltLenA = 4'd0;
    settle = 8;
    repeat (4) @(posedge clk);
  endtask

  task automatic t_wrap;
    int o0, u0;
    setEn(1'b0);
    @(posedge clk); #1; decMode = 1'b1; modVal = 16'd5;
    setEn(1'b1);
    setAB(0, 1);
    o0 = ovfSeen;
    for (int i = 0; i < 3; i++) pulseA(1'b1);
    check("R7 wrap to zero", position, 0);
    check("R7 one overflow strobe", ovfSeen - o0, 1);
    check("R7 dir up at wrap", dirUp, 1);
    setAB(0, 0);
    u0 = unfSeen;
    pulseA(1'b0);
    check("R8 wrap to limit", position, 5);
    check("R8 one underflow strobe", unfSeen - u0, 1);
    check("R8 dir down at wrap", dirUp, 0);
  endtask

  task automatic t_disable;
    int o0, u0;
    setEn(1'b0);
    check("R9 claim released", lowChanClaim, 0);
    o0 = ovfSeen; u0 = unfSeen;
    setAB(0, 1);
    pulseA(1'b1); pulseA(1'b1);
    check("R9 position frozen", position, 5);
    check("R9 no strobes when off", (ovfSeen - o0) + (unfSeen - u0), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    t_reset();
    t_forward();
    t_reverse();
    t_both();
    t_polarity();
    t_cntdir();
    t_filter();
    t_wrap();
    t_disable();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule